// File: doc/BRIEF.md
# Merging Write Buffer with Read Bypass

This block sits between a cache and the next level of memory. It holds pending block-sized writes in a small ring of entries. Each entry covers one four-word block and keeps a valid bit for every byte. A new write to a block that is already buffered is folded into that entry, so it takes no extra slot. Entries are written out to memory in the background, oldest first. A write that needs a fresh slot while every slot is taken is held off with a stall.

A read miss from the cache is looked up in the buffer before it reaches memory. If the buffer holds every byte of the block, the answer comes straight from the buffer and memory is never touched. Otherwise the read goes to memory ahead of all the buffered writes, and any buffered bytes are laid over the returned data. A dirty victim can be pushed in through the write port with all byte enables set just before the read that displaced it. The read is then served first and the victim is drained afterwards.

Top module: `merge_wbuf`

## Requirements
- R1: A write whose block address equals that of an occupied entry updates only the bytes selected by its enables and sets their valid bits. It takes no new slot, so it is accepted without stall even when all slots are occupied.
- R2: A write whose block address matches no occupied entry takes the next free slot. Byte i of a block travels on data bits [8i+7:8i] and is selected by enable bit i. Bytes that were never written stay invalid.
- R3: wrStall is high in the same cycle as a pending write that matches no entry while all ENTRIES slots are occupied. The write is not taken until a slot has drained.
- R4: Entries drain in the order they were allocated. Each drain is a request with memReqWrite=1 that carries the entry's block address, its data and its byte-valid mask as memReqBe. Drains are issued only while rdValid is low and no read is in flight.
- R5: An accepted read that is not fully held in the buffer presents a memory request in the next cycle, with memReqWrite=0, the read's block address and memReqBe=0. This request comes before any buffered write. No drain happens until the read's response has been returned.
- R6: A read whose block is held in the buffer with every byte valid raises rdRespValid in the cycle after acceptance and returns the buffered block. No memory read is presented.
- R7: For any other read, rdRespValid rises in the cycle after memRespValid. The returned block takes each byte from the buffer where that byte is valid and from memory elsewhere.
- R8: A victim block written with all enables set, followed by a read miss to another block, reaches memory after that read.
- R9: After reset the buffer is empty, wrStall and memReqValid are low, rdReady is high and rdRespValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write request |
| wrAddr | input | ADDR_W | Block address of write |
| wrData | input | WORDS*WORD_W | Write data, byte i on bits [8i+7:8i] |
| wrBe | input | WORDS*WORD_W/8 | Byte enables |
| wrStall | output | 1 | Write not taken this cycle |
| rdValid | input | 1 | Read-miss lookup request |
| rdAddr | input | ADDR_W | Block address of read |
| rdReady | output | 1 | Read request can be taken |
| rdRespValid | output | 1 | Read response strobe |
| rdRespData | output | WORDS*WORD_W | Read response block |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts request |
| memReqWrite | output | 1 | 1 for drain, 0 for read |
| memReqAddr | output | ADDR_W | Memory block address |
| memReqData | output | WORDS*WORD_W | Drain data |
| memReqBe | output | WORDS*WORD_W/8 | Drain byte mask, zero for reads |
| memRespValid | input | 1 | Memory read data strobe |
| memRespData | input | WORDS*WORD_W | Memory read data |

## Verification
The stall is combinational, so it is judged in the same cycle the write is driven. A full hit answers one cycle after the accepting edge. A miss puts its memory read on the bus one cycle after acceptance and answers one cycle after the memory strobe. Drains appear one per memory handshake. The bench drives inputs on the falling edge and reads outputs a few nanoseconds later, in the middle of the cycle. For every read it counts how many cycles pass before the response, and it remembers whether the memory strobe was present in the cycle before. Latency is checked from those records, alongside data and the order of logged memory requests.

// File: rtl/merge_wbuf_pkg.sv
`timescale 1ns/1ps
package merge_wbuf_pkg;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_ISSUE = 2'd1,
    RD_WAIT  = 2'd2
  } rdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic allocEn;
    logic mergeEn;
    logic rdCapture;
    logic rdFromBuf;
    logic rdFromMem;
    logic memSelRead;
  } wbStrobe_t;

endpackage

// File: rtl/wbuf_datapath.sv
`timescale 1ns/1ps
module wbuf_datapath
  import merge_wbuf_pkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  parameter int ENTRIES = 4,
  localparam int BLK_W  = WORDS * WORD_W,
  localparam int BE_W   = BLK_W / 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  wbStrobe_t         strobe,
  input  logic [IDX_W-1:0]  allocIdx,
  input  logic [IDX_W-1:0]  mergeIdx,
  input  logic [IDX_W-1:0]  headIdx,
  input  logic [ENTRIES-1:0] entValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BLK_W-1:0]  wrData,
  input  logic [BE_W-1:0]   wrBe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [BLK_W-1:0]  memRespData,
  output logic [ENTRIES-1:0] wrMatchVec,
  output logic              rdFullHit,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [BLK_W-1:0]  memReqData,
  output logic [BE_W-1:0]   memReqBe,
  output logic [BLK_W-1:0]  rdRespData
);

  function automatic logic [BLK_W-1:0] expandBe(input logic [BE_W-1:0] bv);
    logic [BLK_W-1:0] m;
    for (int b = 0; b < BE_W; b++) m[b*8 +: 8] = {8{bv[b]}};
    return m;
  endfunction

  logic [ADDR_W-1:0] entAddr [ENTRIES];
  logic [BLK_W-1:0]  entData [ENTRIES];
  logic [BE_W-1:0]   entBv   [ENTRIES];
  logic [ADDR_W-1:0] rdAddrQ;

  logic [ENTRIES-1:0] rdReqMatch;
  logic [ENTRIES-1:0] rdPendMatch;
  logic [BLK_W-1:0]   reqHitData, pendHitData;
  logic [BE_W-1:0]    reqHitBv, pendHitBv;
  logic [BLK_W-1:0]   wrMask, pendMask;

  assign wrMask   = expandBe(wrBe);
  assign pendMask = expandBe(pendHitBv);

  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_entry
      assign wrMatchVec[gi]  = entValid[gi] && (entAddr[gi] == wrAddr);
      assign rdReqMatch[gi]  = entValid[gi] && (entAddr[gi] == rdAddr);
      assign rdPendMatch[gi] = entValid[gi] && (entAddr[gi] == rdAddrQ);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          entAddr[gi] <= '0;
          entData[gi] <= '0;
          entBv[gi]   <= '0;
        end else if (strobe.allocEn && allocIdx == IDX_W'(gi)) begin
          entAddr[gi] <= wrAddr;
          entData[gi] <= wrData & wrMask;
          entBv[gi]   <= wrBe;
        end else if (strobe.mergeEn && mergeIdx == IDX_W'(gi)) begin
          entData[gi] <= (entData[gi] & ~wrMask) | (wrData & wrMask);
          entBv[gi]   <= entBv[gi] | wrBe;
        end
      end
    end
  endgenerate

  // gather the (single) matching entry for the lookup and pending addresses
  always_comb begin
    reqHitData  = '0;
    reqHitBv    = '0;
    pendHitData = '0;
    pendHitBv   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rdReqMatch[i]) begin
        reqHitData = reqHitData | entData[i];
        reqHitBv   = reqHitBv | entBv[i];
      end
      if (rdPendMatch[i]) begin
        pendHitData = pendHitData | entData[i];
        pendHitBv   = pendHitBv | entBv[i];
      end
    end
  end

  assign rdFullHit = (|rdReqMatch) && (&reqHitBv);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddrQ    <= '0;
      rdRespData <= '0;
    end else begin
      if (strobe.rdCapture) rdAddrQ <= rdAddr;
      if (strobe.rdFromBuf) rdRespData <= reqHitData;
      else if (strobe.rdFromMem)
        rdRespData <= (memRespData & ~pendMask) | (pendHitData & pendMask);
    end
  end

  assign memReqAddr = strobe.memSelRead ? rdAddrQ : entAddr[headIdx];
  assign memReqData = entData[headIdx];
  assign memReqBe   = strobe.memSelRead ? '0 : entBv[headIdx];

  // R1: a block address is owned by at most one occupied entry
  assert_single_owner_R1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(wrMatchVec) <= 1);
  assert_single_lookup_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rdReqMatch) <= 1);

endmodule

// File: rtl/wbuf_control.sv
`timescale 1ns/1ps
module wbuf_control
  import merge_wbuf_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrValid,
  input  logic [ENTRIES-1:0] wrMatchVec,
  input  logic               rdValid,
  input  logic               rdFullHit,
  input  logic               memReqReady,
  input  logic               memRespValid,
  output wbStrobe_t          strobe,
  output logic [IDX_W-1:0]   allocIdx,
  output logic [IDX_W-1:0]   mergeIdx,
  output logic [IDX_W-1:0]   headIdx,
  output logic [ENTRIES-1:0] entValid,
  output logic               wrStall,
  output logic               rdReady,
  output logic               rdRespValid,
  output logic               memReqValid,
  output logic               memReqWrite
);

  function automatic logic [IDX_W-1:0] nextIdx(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  rdState_e          rdState;
  logic [IDX_W-1:0]  headQ, tailQ;
  logic [CNT_W-1:0]  countQ;
  logic              isFull, drainReq, drainFire;
  logic              rdAccept, matchAny, wrFire, allocEn, mergeEn;
  logic [ENTRIES-1:0] drainMask, matchEff;

  assign isFull   = (countQ == CNT_W'(ENTRIES));
  assign rdReady  = (rdState == RD_IDLE);
  assign rdAccept = rdValid && rdReady;

  // drain only with no read pending or in flight
  assign drainReq  = (rdState == RD_IDLE) && !rdValid && (countQ != '0);
  assign drainFire = drainReq && memReqReady;

  assign memReqValid = (rdState == RD_ISSUE) || drainReq;
  assign memReqWrite = (rdState != RD_ISSUE);

  // the head being written out this cycle cannot take a merge
  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      drainMask[i] = drainFire && (headQ == IDX_W'(i));
  end
  assign matchEff = wrMatchVec & ~drainMask;
  assign matchAny = |matchEff;

  assign wrStall = wrValid && !matchAny && isFull;
  assign wrFire  = wrValid && !wrStall;
  assign mergeEn = wrFire && matchAny;
  assign allocEn = wrFire && !matchAny;

  always_comb begin
    mergeIdx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (matchEff[i]) mergeIdx = IDX_W'(i);
  end

  assign allocIdx = tailQ;
  assign headIdx  = headQ;

  assign strobe.allocEn    = allocEn;
  assign strobe.mergeEn    = mergeEn;
  assign strobe.rdCapture  = rdAccept;
  assign strobe.rdFromBuf  = rdAccept && rdFullHit;
  assign strobe.rdFromMem  = (rdState == RD_WAIT) && memRespValid;
  assign strobe.memSelRead = (rdState == RD_ISSUE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ    <= '0;
      tailQ    <= '0;
      countQ   <= '0;
      entValid <= '0;
    end else begin
      if (drainFire) begin
        entValid[headQ] <= 1'b0;
        headQ <= nextIdx(headQ);
      end
      if (allocEn) begin
        entValid[tailQ] <= 1'b1;
        tailQ <= nextIdx(tailQ);
      end
      case ({allocEn, drainFire})
        2'b10:   countQ <= countQ + 1'b1;
        2'b01:   countQ <= countQ - 1'b1;
        default: countQ <= countQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdState     <= RD_IDLE;
      rdRespValid <= 1'b0;
    end else begin
      rdRespValid <= 1'b0;
      case (rdState)
        RD_IDLE: if (rdAccept) begin
          if (rdFullHit) rdRespValid <= 1'b1;
          else           rdState <= RD_ISSUE;
        end
        RD_ISSUE: if (memReqReady) rdState <= RD_WAIT;
        RD_WAIT: if (memRespValid) begin
          rdRespValid <= 1'b1;
          rdState     <= RD_IDLE;
        end
        default: rdState <= RD_IDLE;
      endcase
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_W'(ENTRIES));
  assert_merge_no_slot_R1: assert property (@(posedge clk) disable iff (!rstN)
    (mergeEn && !drainFire) |=> countQ == $past(countQ));
  assert_stall_when_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrStall |-> isFull);
  assert_drain_valid_head_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> entValid[headQ]);
  assert_read_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdState != RD_IDLE) |-> !(memReqValid && memReqWrite));
  assert_hit_no_mem_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdAccept && rdFullHit) |=> !(memReqValid && !memReqWrite));
  assert_resp_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdRespValid |-> ($past(rdAccept) || $past(memRespValid)));

endmodule

// File: rtl/merge_wbuf.sv
`timescale 1ns/1ps
module merge_wbuf
  import merge_wbuf_pkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  parameter int ENTRIES = 4,
  localparam int BLK_W  = WORDS * WORD_W,
  localparam int BE_W   = BLK_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BLK_W-1:0]  wrData,
  input  logic [BE_W-1:0]   wrBe,
  output logic              wrStall,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdReady,
  output logic              rdRespValid,
  output logic [BLK_W-1:0]  rdRespData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [BLK_W-1:0]  memReqData,
  output logic [BE_W-1:0]   memReqBe,
  input  logic              memRespValid,
  input  logic [BLK_W-1:0]  memRespData
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  wbStrobe_t          strobe;
  logic [IDX_W-1:0]   allocIdx, mergeIdx, headIdx;
  logic [ENTRIES-1:0] entValid, wrMatchVec;
  logic               rdFullHit;

  wbuf_control #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrMatchVec(wrMatchVec),
    .rdValid(rdValid), .rdFullHit(rdFullHit),
    .memReqReady(memReqReady), .memRespValid(memRespValid),
    .strobe(strobe), .allocIdx(allocIdx), .mergeIdx(mergeIdx),
    .headIdx(headIdx), .entValid(entValid), .wrStall(wrStall),
    .rdReady(rdReady), .rdRespValid(rdRespValid),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite)
  );

  wbuf_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS),
                  .ENTRIES(ENTRIES)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .allocIdx(allocIdx), .mergeIdx(mergeIdx), .headIdx(headIdx),
    .entValid(entValid), .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe),
    .rdAddr(rdAddr), .memRespData(memRespData),
    .wrMatchVec(wrMatchVec), .rdFullHit(rdFullHit),
    .memReqAddr(memReqAddr), .memReqData(memReqData), .memReqBe(memReqBe),
    .rdRespData(rdRespData)
  );

endmodule

// File: tb/merge_wbuf_tb_top.sv
`timescale 1ns/1ps
module merge_wbuf_tb_top;

  localparam int AW = 28;
  localparam int BW = 128;
  localparam int EW = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          wrValid, rdValid, memReqReady, memRespValid;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [BW-1:0] wrData, memRespData;
  logic [EW-1:0] wrBe;
  logic          wrStall, rdReady, rdRespValid, memReqValid, memReqWrite;
  logic [BW-1:0] rdRespData, memReqData;
  logic [AW-1:0] memReqAddr;
  logic [EW-1:0] memReqBe;

  always #4 clk = ~clk;

  merge_wbuf dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrBe(wrBe), .wrStall(wrStall),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdReady(rdReady),
    .rdRespValid(rdRespValid), .rdRespData(rdRespData),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqData(memReqData), .memReqBe(memReqBe),
    .memRespValid(memRespValid), .memRespData(memRespData)
  );

  int checks = 0;
  int errors = 0;

  function automatic logic [BW-1:0] memFn(input logic [AW-1:0] a);
    logic [BW-1:0] r;
    for (int b = 0; b < EW; b++) r[b*8 +: 8] = 8'(a * 7 + b * 13 + 5);
    return r;
  endfunction

  function automatic logic [BW-1:0] patFn(input logic [AW-1:0] a, input int t);
    logic [BW-1:0] r;
    for (int b = 0; b < EW; b++) r[b*8 +: 8] = 8'(a * 3 + b * 29 + t * 11 + 1);
    return r;
  endfunction

  function automatic logic [BW-1:0] maskOf(input logic [EW-1:0] be);
    logic [BW-1:0] m;
    for (int b = 0; b < EW; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: logs handshakes, answers reads three cycles later
  logic          evWr   [64];
  logic [AW-1:0] evAddr [64];
  logic [BW-1:0] evData [64];
  logic [EW-1:0] evBe   [64];
  int            evN = 0;
  int            readsSeen = 0;
  int            respTimer = 0;
  logic [AW-1:0] respAddr = '0;

  initial begin
    memRespValid = 1'b0;
    memRespData  = '0;
    forever begin
      @(negedge clk); #2;
      memRespValid = 1'b0;
      if (respTimer == 1) begin
        memRespValid = 1'b1;
        memRespData  = memFn(respAddr);
      end
      if (respTimer > 0) respTimer--;
      if (rstN && memReqValid) begin
        if (!memReqWrite) readsSeen++;
        if (memReqReady) begin
          if (evN < 64) begin
            evWr[evN] = memReqWrite; evAddr[evN] = memReqAddr;
            evData[evN] = memReqData; evBe[evN] = memReqBe;
          end
          evN++;
          if (!memReqWrite) begin
            respAddr  = memReqAddr;
            respTimer = 3;
          end
        end
      end
    end
  end

  task automatic doWrite(input logic [AW-1:0] a, input logic [BW-1:0] d,
                         input logic [EW-1:0] be, output int stalls);
    stalls = 0;
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d; wrBe = be;
    #3;
    while (wrStall) begin
      stalls++;
      @(negedge clk); #3;
    end
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic doRead(input logic [AW-1:0] a, input logic readyAfter,
                        output logic [BW-1:0] data, output int lat,
                        output bit prevMem);
    bit prev;
    @(negedge clk);
    rdValid = 1'b1; rdAddr = a;
    #3;
    chk(rdReady == 1'b1, "R5 rdReady before read", BW'(rdReady), BW'(1));
    @(negedge clk);
    rdValid = 1'b0; memReqReady = readyAfter;
    #3;
    lat = 0; prev = 1'b0;
    while (!rdRespValid && lat < 60) begin
      prev = memRespValid;
      @(negedge clk); #3;
      lat++;
    end
    data = rdRespData; prevMem = prev;
  endtask

  task automatic waitDrained();
    int n = 0;
    @(negedge clk); #3;
    while ((memReqValid || !rdReady || respTimer != 0) && n < 100) begin
      @(negedge clk); #3;
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [BW-1:0] data, exp10, expD;
    int stalls, lat, base;
    bit prevMem;
    int r0;

    rstN = 1'b0; wrValid = 1'b0; rdValid = 1'b0; memReqReady = 1'b0;
    wrAddr = '0; rdAddr = '0; wrData = '0; wrBe = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #3;
    // R9: reset state
    chk(wrStall == 1'b0, "R9 wrStall", BW'(wrStall), BW'(0));
    chk(memReqValid == 1'b0, "R9 memReqValid", BW'(memReqValid), BW'(0));
    chk(rdReady == 1'b1, "R9 rdReady", BW'(rdReady), BW'(1));
    chk(rdRespValid == 1'b0, "R9 rdRespValid", BW'(rdRespValid), BW'(0));
    @(negedge clk); rstN = 1'b1;

    // R1/R2: build block 0x10 word by word, memory held off
    for (int w = 0; w < 4; w++) begin
      doWrite(28'h10, patFn(28'h10, w), EW'(16'hF << (4 * w)), stalls);
      chk(stalls == 0, "R2 alloc/merge no stall", BW'(stalls), BW'(0));
    end
    for (int b = 0; b < EW; b++) exp10[b*8 +: 8] = patFn(28'h10, b / 4) >> (b * 8);

    // R6: full hit served from buffer next cycle, no memory read
    r0 = readsSeen;
    doRead(28'h10, 1'b0, data, lat, prevMem);
    chk(lat == 0, "R6 full-hit latency", BW'(lat), BW'(0));
    chk(data == exp10, "R6 full-hit data", data, exp10);
    chk(readsSeen == r0, "R6 no memory read", BW'(readsSeen), BW'(r0));

    // fill remaining slots
    for (int k = 2; k <= 4; k++) doWrite(AW'(k * 16), patFn(AW'(k * 16), 0), 16'hFFFF, stalls);
    // R1: merge accepted while full
    doWrite(28'h10, patFn(28'h10, 9), 16'h0001, stalls);
    chk(stalls == 0, "R1 merge while full", BW'(stalls), BW'(0));
    exp10[7:0] = patFn(28'h10, 9) >> 0;

    // R3: new block while full stalls until a drain
    @(negedge clk);
    wrValid = 1'b1; wrAddr = 28'h50; wrData = patFn(28'h50, 0); wrBe = 16'hFFFF;
    #3;
    chk(wrStall == 1'b1, "R3 stall when full", BW'(wrStall), BW'(1));
    @(negedge clk);
    memReqReady = 1'b1;
    #3;
    stalls = 0;
    while (wrStall && stalls < 20) begin
      @(negedge clk); #3; stalls++;
    end
    chk(wrStall == 1'b0, "R3 stall released after drain", BW'(wrStall), BW'(0));
    @(negedge clk); wrValid = 1'b0;
    waitDrained();

    // R4: oldest-first drain with byte-valid mask
    chk(evN == 5, "R4 drain count", BW'(evN), BW'(5));
    for (int k = 0; k < 5; k++) begin
      chk(evWr[k] == 1'b1 && evAddr[k] == AW'((k + 1) * 16),
          "R4 drain order", BW'(evAddr[k]), BW'((k + 1) * 16));
      chk(evBe[k] == 16'hFFFF, "R4 drain mask", BW'(evBe[k]), BW'(16'hFFFF));
    end
    chk(evData[0] == exp10, "R1 merged drain data", evData[0], exp10);
    chk(evData[4] == patFn(28'h50, 0), "R4 drain data", evData[4], patFn(28'h50, 0));

    // R5/R8: victim and partial entry pending, read miss goes first
    memReqReady = 1'b0;
    base = evN;
    doWrite(28'h60, patFn(28'h60, 1), 16'hFFFF, stalls);
    doWrite(28'h70, patFn(28'h70, 2), 16'h00FF, stalls);
    doRead(28'h80, 1'b1, data, lat, prevMem);
    chk(data == memFn(28'h80), "R5 miss data", data, memFn(28'h80));
    chk(prevMem == 1'b1, "R7 response after memory strobe", BW'(prevMem), BW'(1));
    waitDrained();
    chk(evN == base + 3, "R8 request count", BW'(evN - base), BW'(3));
    chk(evWr[base] == 1'b0 && evAddr[base] == 28'h80 && evBe[base] == '0,
        "R5 read issued first", BW'(evAddr[base]), BW'(28'h80));
    chk(evWr[base+1] == 1'b1 && evAddr[base+1] == 28'h60,
        "R8 victim after read", BW'(evAddr[base+1]), BW'(28'h60));
    chk(evWr[base+2] == 1'b1 && evAddr[base+2] == 28'h70 && evBe[base+2] == 16'h00FF,
        "R2 partial entry mask", BW'(evBe[base+2]), BW'(16'h00FF));
    chk(evData[base+2] == (patFn(28'h70, 2) & maskOf(16'h00FF)),
        "R2 unwritten bytes invalid", evData[base+2], patFn(28'h70, 2) & maskOf(16'h00FF));

    // R7: sweep of partial hits, buffered bytes over memory bytes
    for (int k = 0; k < 8; k++) begin
      logic [EW-1:0] be;
      logic [AW-1:0] a;
      a  = AW'(256 + k);
      be = (k == 0) ? 16'h0 :
           EW'((32'h1 << k) | (32'hC000 >> k) | ((k % 2) ? 32'h0F00 : 32'h00F0));
      memReqReady = 1'b0;
      doWrite(a, patFn(a, k + 20), be, stalls);
      doRead(a, 1'b1, data, lat, prevMem);
      expD = (patFn(a, k + 20) & maskOf(be)) | (memFn(a) & ~maskOf(be));
      chk(data == expD, "R7 merged read data", data, expD);
      chk(prevMem == 1'b1, "R7 response timing", BW'(prevMem), BW'(1));
      waitDrained();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule